// File: doc/BRIEF.md
# Keyboard Command and Scancode Responder

This block is the keyboard side of a serial channel. The host sends it command bytes. For certain commands the block answers by loading fixed reply bytes into a receive queue, which the host then reads one byte at a time through its data port. The block also accepts raw scancode events from a key matrix front end. Each event passes through a filter for the extended-key prefix and the caps-lock and num-lock keys. It is then mapped through a 128-entry translation table chosen by the extended flag. The result, with the release flag added back, goes into the same queue.

The queue takes at most one write per clock. A multi-byte reply is written by a small sequencer, one byte per cycle. While that reply is being written the sequencer holds off further commands and scancodes. A command offered on the same cycle as a scancode has priority over it. The two translation tables are parameters of the block.

Top module: `kbd_proto_engine`

## Requirements
- R1: After reset the queue is empty, `rx_avail` and `rd_data` are 0, and `cmd_ready` is 1.
- R2: Command 0x01 empties the queue at the edge where it is accepted. On the three following edges it writes 0xFF, then 0x04, then 0x7F. `cmd_ready` is 0 from that acceptance until the last byte has been written.
- R3: Command 0x0E writes nothing to the queue. The next accepted command byte, whatever its value, is then discarded.
- R4: Commands 0x07 and 0x0F empty the queue on acceptance and then write 0xFE and 0x00 on the two following edges.
- R5: Every command byte other than 0x01, 0x07, 0x0E and 0x0F leaves the queue and the block state unchanged.
- R6: Scancode 0xE0 writes nothing and sets an extended flag. The next scancode that is not dropped is translated with `EXT_MAP` and clears the flag. All other scancodes use `NORM_MAP`.
- R7: A translated byte is table entry `code[6:0]` (byte k of the map vector sits at bits 8k+7..8k), with bit 7 set to `code[7]`. It is written to the queue at the edge that accepts the scancode.
- R8: Caps lock (0x3A press, 0xBA release) keeps a 2-bit mode that is 0 at reset. A press flips bit 0 and is dropped if the mode becomes 2. A release flips bit 1 and is dropped if the mode becomes 3.
- R9: Num lock (0x45 press, 0xC5 release) follows the same 2-bit rule as R8, with its own mode.
- R10: The queue holds `QDEPTH` (256) bytes. A write that finds it full is discarded, and the stored bytes come out in the order they were written.
- R11: Each `rd_en` pulse removes the oldest byte and presents it on `rd_data` after the next edge. On an empty queue it presents 0.
- R12: `rx_avail` is 1 exactly when the queue holds at least one byte.
- R13: `scan_ready` is 0 while a reply is being written or while `cmd_valid` is 1. A scancode offered while `scan_ready` is 0 is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A host command byte is offered |
| cmd_byte | input | 8 | Host command byte |
| cmd_ready | output | 1 | The block takes a command this cycle |
| scan_valid | input | 1 | A raw scancode event is offered |
| scan_code | input | 8 | Raw scancode; bit 7 marks a release |
| scan_ready | output | 1 | The block takes a scancode this cycle |
| rd_en | input | 1 | Pop one byte from the receive queue |
| rd_data | output | 8 | Byte popped by the last `rd_en` (0 if the queue was empty) |
| rx_avail | output | 1 | The receive queue is not empty |

## Verification
A scancode that is accepted shows up in `rx_avail` and in the queue one edge after its acceptance. A reply byte lands one edge after acceptance and then one per edge. `rd_data` updates on the edge that samples `rd_en`, and `scan_ready` follows `cmd_valid` within the same cycle. The bench drives inputs one time unit after the falling edge. It updates a behavioural queue model on every rising edge from the same inputs. At every falling edge, where all of these effects have settled, it compares all four outputs with the model.

// File: rtl/kbd_proto_pkg.sv
package kbd_proto_pkg;

  localparam int XLATE_ENTRIES = 128;
  localparam int XLATE_IDX_W   = $clog2(XLATE_ENTRIES);

  typedef logic [XLATE_ENTRIES*8-1:0] xlate_map_t;

  // host command codes
  localparam logic [7:0] CMD_IDENTIFY = 8'h01;
  localparam logic [7:0] CMD_LAMPS    = 8'h0E;
  localparam logic [7:0] CMD_LAYOUT_A = 8'h07;
  localparam logic [7:0] CMD_LAYOUT_B = 8'h0F;

  // scancodes with special handling
  localparam logic [7:0] SC_PREFIX    = 8'hE0;
  localparam logic [7:0] SC_CAPS_DN   = 8'h3A;
  localparam logic [7:0] SC_CAPS_UP   = 8'hBA;
  localparam logic [7:0] SC_NUM_DN    = 8'h45;
  localparam logic [7:0] SC_NUM_UP    = 8'hC5;

  localparam int IDENT_LEN  = 3;
  localparam int LAYOUT_LEN = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_IDENT = 2'd1,
    SEQ_LAYOUT= 2'd2
  } seq_state_e;

  function automatic logic [7:0] ident_byte(input logic [1:0] k);
    case (k)
      2'd0:    ident_byte = 8'hFF;
      2'd1:    ident_byte = 8'h04;
      default: ident_byte = 8'h7F;
    endcase
  endfunction

  function automatic logic [7:0] layout_byte(input logic [1:0] k);
    layout_byte = (k == 2'd0) ? 8'hFE : 8'h00;
  endfunction

  // default map: entry k holds k XOR the given pattern, top bit kept clear
  function automatic xlate_map_t build_map(input logic [6:0] pat);
    xlate_map_t m;
    for (int k = 0; k < XLATE_ENTRIES; k++) begin
      m[k*8 +: 8] = {1'b0, (7'(k) ^ pat)};
    end
    return m;
  endfunction

endpackage

// File: rtl/kbd_rx_fifo.sv
module kbd_rx_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          not_empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rdat_q, rdat_d;
  logic          do_push, do_pop;

  always_comb begin
    do_push = 1'b0;
    do_pop  = 1'b0;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    cnt_d   = cnt_q;
    rdat_d  = rdat_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
      if (rd_en) rdat_d = '0;
    end else begin
      do_push = wr_en && (cnt_q != FULL_CNT);
      do_pop  = rd_en && (cnt_q != '0);
      if (rd_en) rdat_d = do_pop ? store[rptr_q] : '0;
      if (do_pop)  rptr_d = (rptr_q == LAST_PTR) ? '0 : rptr_q + 1'b1;
      if (do_push) wptr_d = (wptr_q == LAST_PTR) ? '0 : wptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      rdat_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      rdat_q <= rdat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wptr_q] <= wr_data;
  end

  assign rd_data   = rdat_q;
  assign not_empty = (cnt_q != '0);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R11
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !not_empty) |=> (rd_data == '0));

  // R2
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !not_empty);

endmodule

// File: rtl/kbd_cmd_seq.sv
module kbd_cmd_seq
  import kbd_proto_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_fire,
  input  logic [7:0] cmd_byte,
  output logic       idle,
  output logic       flush,
  output logic       wr_en,
  output logic [7:0] wr_data
);

  localparam logic [1:0] IDENT_LAST  = 2'(IDENT_LEN - 1);
  localparam logic [1:0] LAYOUT_LAST = 2'(LAYOUT_LEN - 1);

  seq_state_e st_q, st_d;
  logic [1:0] pos_q, pos_d;
  logic       skip_q, skip_d;

  always_comb begin
    st_d    = st_q;
    pos_d   = pos_q;
    skip_d  = skip_q;
    flush   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    case (st_q)
      SEQ_IDLE: begin
        if (cmd_fire) begin
          if (skip_q) begin
            skip_d = 1'b0;
          end else begin
            case (cmd_byte)
              CMD_IDENTIFY: begin
                flush = 1'b1;
                st_d  = SEQ_IDENT;
                pos_d = '0;
              end
              CMD_LAMPS: skip_d = 1'b1;
              CMD_LAYOUT_A, CMD_LAYOUT_B: begin
                flush = 1'b1;
                st_d  = SEQ_LAYOUT;
                pos_d = '0;
              end
              default: ;
            endcase
          end
        end
      end
      SEQ_IDENT: begin
        wr_en   = 1'b1;
        wr_data = ident_byte(pos_q);
        if (pos_q == IDENT_LAST) begin
          st_d  = SEQ_IDLE;
          pos_d = '0;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
      SEQ_LAYOUT: begin
        wr_en   = 1'b1;
        wr_data = layout_byte(pos_q);
        if (pos_q == LAYOUT_LAST) begin
          st_d  = SEQ_IDLE;
          pos_d = '0;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      pos_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      skip_q <= skip_d;
    end
  end

  assign idle = (st_q == SEQ_IDLE);

  // R2
  ident_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !skip_q && cmd_byte == CMD_IDENTIFY) |=> (wr_en && wr_data == 8'hFF));

  // R3
  lamp_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && skip_q) |=> (idle && !skip_q));

endmodule

// File: rtl/kbd_scan_xlate.sv
module kbd_scan_xlate
  import kbd_proto_pkg::*;
#(
  parameter xlate_map_t NORM_MAP = build_map(7'h00),
  parameter xlate_map_t EXT_MAP  = build_map(7'h40)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scan_fire,
  input  logic [7:0] scan_code,
  output logic       wr_en,
  output logic [7:0] wr_data
);

  logic       ext_q, ext_d;
  logic [1:0] caps_q, caps_d, num_q, num_d;
  logic       drop;
  logic [XLATE_IDX_W-1:0] idx;
  logic [7:0] looked;

  assign idx    = scan_code[XLATE_IDX_W-1:0];
  assign looked = ext_q ? EXT_MAP[idx*8 +: 8] : NORM_MAP[idx*8 +: 8];

  always_comb begin
    ext_d  = ext_q;
    caps_d = caps_q;
    num_d  = num_q;
    drop   = 1'b0;
    if (scan_fire) begin
      case (scan_code)
        SC_CAPS_DN: begin caps_d = caps_q ^ 2'b01; drop = (caps_d == 2'b10); end
        SC_CAPS_UP: begin caps_d = caps_q ^ 2'b10; drop = (caps_d == 2'b11); end
        SC_NUM_DN:  begin num_d  = num_q  ^ 2'b01; drop = (num_d  == 2'b10); end
        SC_NUM_UP:  begin num_d  = num_q  ^ 2'b10; drop = (num_d  == 2'b11); end
        SC_PREFIX:  begin ext_d  = 1'b1;           drop = 1'b1;              end
        default: ;
      endcase
      if (!drop) ext_d = 1'b0;
    end
    wr_en   = scan_fire && !drop;
    wr_data = looked | {scan_code[7], 7'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      caps_q <= '0;
      num_q  <= '0;
    end else if (scan_fire) begin
      ext_q  <= ext_d;
      caps_q <= caps_d;
      num_q  <= num_d;
    end
  end

  // R6
  prefix_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_fire && scan_code == SC_PREFIX) |-> !wr_en);

  // R6
  prefix_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_fire && wr_en) |=> !ext_q);

  // R7
  release_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[7] == scan_code[7] || looked[7]));

endmodule

// File: rtl/kbd_proto_engine.sv
module kbd_proto_engine
  import kbd_proto_pkg::*;
#(
  parameter int         QDEPTH   = 256,
  parameter xlate_map_t NORM_MAP = build_map(7'h00),
  parameter xlate_map_t EXT_MAP  = build_map(7'h40)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       cmd_ready,
  input  logic       scan_valid,
  input  logic [7:0] scan_code,
  output logic       scan_ready,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rx_avail
);

  logic       seq_idle, seq_flush, seq_wr, scan_wr;
  logic [7:0] seq_data, scan_data;
  logic       cmd_fire, scan_fire;
  logic       q_wr;
  logic [7:0] q_data;

  assign cmd_ready  = seq_idle;
  assign scan_ready = seq_idle && !cmd_valid;
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign scan_fire  = scan_valid && scan_ready;

  kbd_cmd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_fire (cmd_fire),
    .cmd_byte (cmd_byte),
    .idle     (seq_idle),
    .flush    (seq_flush),
    .wr_en    (seq_wr),
    .wr_data  (seq_data)
  );

  kbd_scan_xlate #(
    .NORM_MAP (NORM_MAP),
    .EXT_MAP  (EXT_MAP)
  ) u_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_fire (scan_fire),
    .scan_code (scan_code),
    .wr_en     (scan_wr),
    .wr_data   (scan_data)
  );

  assign q_wr   = seq_wr || scan_wr;
  assign q_data = seq_wr ? seq_data : scan_data;

  kbd_rx_fifo #(
    .DEPTH (QDEPTH),
    .DW    (8)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (seq_flush),
    .wr_en     (q_wr),
    .wr_data   (q_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .not_empty (rx_avail)
  );

  // R13
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_wr, scan_wr, seq_flush}));

  // R13
  scan_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_idle || cmd_valid) |-> !scan_wr);

endmodule

// File: tb/kbd_proto_engine_tb.sv
module kbd_proto_engine_tb;
  import kbd_proto_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;

  function automatic xlate_map_t tb_map(input int sel);
    xlate_map_t m;
    for (int k = 0; k < 128; k++) begin
      if (sel == 0) m[k*8 +: 8] = 8'((k * 5 + 3) % 128);
      else          m[k*8 +: 8] = 8'(127 - k);
    end
    return m;
  endfunction

  localparam xlate_map_t TB_NORM = tb_map(0);
  localparam xlate_map_t TB_EXT  = tb_map(1);

  logic clk, rst_n;
  logic cmd_valid, scan_valid, rd_en;
  logic [7:0] cmd_byte, scan_code;
  logic cmd_ready, scan_ready, rx_avail;
  logic [7:0] rd_data;

  kbd_proto_engine #(.QDEPTH(DEPTH), .NORM_MAP(TB_NORM), .EXT_MAP(TB_EXT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
    .scan_valid(scan_valid), .scan_code(scan_code), .scan_ready(scan_ready),
    .rd_en(rd_en), .rd_data(rd_data), .rx_avail(rx_avail)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;
  bit done   = 0;
  string cur_req = "R1";

  // reference model
  logic [7:0] mq[$];
  logic [7:0] m_pend[$];
  logic [7:0] m_rd;
  bit m_led, m_ext;
  int m_caps, m_num;

  always @(posedge clk or negedge rst_n) begin : model
    int sz0, idx;
    bit do_flush, do_wr, acc_cmd, acc_scan, drop;
    logic [7:0] wv, c;
    if (!rst_n) begin
      mq.delete(); m_pend.delete();
      m_rd = 0; m_led = 0; m_ext = 0; m_caps = 0; m_num = 0;
    end else begin
      acc_cmd  = cmd_valid && (m_pend.size() == 0);
      acc_scan = scan_valid && (m_pend.size() == 0) && !cmd_valid;
      do_flush = 0; do_wr = 0; wv = 0;
      if (m_pend.size() > 0) begin
        do_wr = 1; wv = m_pend.pop_front();
      end else if (acc_cmd) begin
        if (m_led) m_led = 0;
        else if (cmd_byte == 8'h01) begin do_flush = 1; m_pend = '{8'hFF, 8'h04, 8'h7F}; end
        else if (cmd_byte == 8'h0E) m_led = 1;
        else if (cmd_byte == 8'h07 || cmd_byte == 8'h0F) begin do_flush = 1; m_pend = '{8'hFE, 8'h00}; end
      end
      if (acc_scan) begin
        c = scan_code; drop = 0;
        if (c == 8'h3A)      begin m_caps ^= 1; drop = (m_caps == 2); end
        else if (c == 8'hBA) begin m_caps ^= 2; drop = (m_caps == 3); end
        else if (c == 8'h45) begin m_num  ^= 1; drop = (m_num  == 2); end
        else if (c == 8'hC5) begin m_num  ^= 2; drop = (m_num  == 3); end
        else if (c == 8'hE0) begin m_ext = 1; drop = 1; end
        if (!drop) begin
          idx = int'(c[6:0]);
          wv = m_ext ? 8'(127 - idx) : 8'((idx * 5 + 3) % 128);
          wv = wv | (c & 8'h80);
          m_ext = 0; do_wr = 1;
        end
      end
      sz0 = mq.size();
      if (do_flush) begin
        mq.delete();
        if (rd_en) m_rd = 0;
      end else if (rd_en) begin
        if (sz0 > 0) m_rd = mq.pop_front(); else m_rd = 0;
      end
      if (do_wr && sz0 < DEPTH) mq.push_back(wv);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cur_req, "rd_data", int'(rd_data), int'(m_rd));
      chk("R12", "rx_avail", int'(rx_avail), int'(mq.size() != 0));
      chk(cur_req, "cmd_ready", int'(cmd_ready), int'(m_pend.size() == 0));
      chk("R13", "scan_ready", int'(scan_ready), int'((m_pend.size() == 0) && !cmd_valid));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle_inputs();
    cmd_valid = 0; scan_valid = 0; rd_en = 0; cmd_byte = 0; scan_code = 0;
  endtask

  task automatic scan(input logic [7:0] c);
    scan_valid = 1; scan_code = c; tick(); scan_valid = 0;
  endtask

  task automatic cmd(input logic [7:0] b);
    cmd_valid = 1; cmd_byte = b; tick(); cmd_valid = 0;
  endtask

  task automatic reads(input int n);
    for (int i = 0; i < n; i++) begin rd_en = 1; tick(); end
    rd_en = 0;
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cmp_on = 1;
    cur_req = "R1";   tick(); tick();
    cur_req = "R11";  reads(2);
    cur_req = "R7";
    scan(8'h05); scan(8'h85); scan(8'h7F); scan(8'h00); reads(5);
    cur_req = "R6";
    scan(8'hE0); scan(8'h1C); scan(8'h1C); scan(8'hE0); scan(8'hE0); scan(8'h9C); reads(4);
    cur_req = "R8";
    scan(8'h3A); scan(8'hBA); scan(8'h3A); scan(8'hBA); scan(8'h3A); scan(8'hBA); reads(5);
    cur_req = "R9";
    scan(8'h45); scan(8'hC5); scan(8'hE0); scan(8'h45); scan(8'h20); scan(8'hC5); reads(5);
    cur_req = "R2";
    scan(8'h11); scan(8'h12);
    cmd(8'h01);
    // hold a second command and a scancode while the reply is written (R13)
    cmd_valid = 1; cmd_byte = 8'h0F; scan_valid = 1; scan_code = 8'h33;
    tick(); tick(); tick();
    cur_req = "R4";
    tick(); cmd_valid = 0; tick(); tick(); scan_valid = 0;
    reads(6);
    cur_req = "R3";
    scan(8'h21); cmd(8'h0E); tick(); cmd(8'h01); tick(); tick(); reads(3);
    cur_req = "R5";
    scan(8'h22); cmd(8'h00); cmd(8'h55); cmd(8'hFF); cmd(8'h02); tick(); reads(3);
    cur_req = "R4";
    scan(8'h23); cmd(8'h07); tick(); tick(); reads(4);
    cur_req = "R10";
    for (int i = 0; i < DEPTH + 4; i++) scan(8'(i % 128));
    scan_valid = 1; scan_code = 8'h44; rd_en = 1; tick(); scan_valid = 0; rd_en = 0;
    scan(8'h45);
    reads(DEPTH + 3);
    cur_req = "R11";
    reads(2);
    tick(); tick();
    finish_run();
  end

endmodule